// File: doc/BRIEF.md
# Word Parity Generator with Whole-Packet Parity Corruption

This block sits on the path of a packet stream going into a switch core. It attaches one even-parity bit to every 32-bit word that passes, so that later stages can detect corruption of stored or forwarded data. Packets the switch builds itself travel the same path, so they are covered the same way. Parity generation has no off switch.

For testing the checkers further down the path, a corruption mode can invert the parity of selected packets. Corruption applies to a whole packet. A packet is chosen when the mode is enabled and the 10-bit length field in its first (header) word equals a programmed match value. The choice is made on the header word itself, so the header word is also corrupted. The choice then holds for the rest of that packet. The block adds one register stage, and output framing and data are the input delayed by one cycle.

Top module: `wpar_gen`

## Requirements
- R1: With corruption not selected, `out_par` is set so that the number of ones in {`out_data`, `out_par`} is even.
- R2: A word accepted with `in_valid` high appears on `out_valid`, `out_sop`, `out_eop` and `out_data` on the next clock edge with identical values. `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R3: While `cfg_bad_en` is low, every word gets correct parity, whatever the value of `cfg_match_len`.
- R4: When `cfg_bad_en` is high on the start word and bits [9:0] of that word equal `cfg_match_len`, every word of that packet, the start word included, gets inverted parity.
- R5: When `cfg_bad_en` is high but the start word's bits [9:0] differ from `cfg_match_len`, every word of the packet gets correct parity.
- R6: The decision to corrupt is taken only on the start word. Changes to `cfg_bad_en` or `cfg_match_len` later in the packet do not alter the parity of that packet's remaining words.
- R7: A one-word packet (`in_sop` and `in_eop` both high) follows R4 and R5 on that single word.
- R8: During reset `out_valid` is low.
- R9: Idle cycles (`in_valid` low) inside a packet keep the packet's corruption decision.
- R10: A valid word that arrives outside any packet (no start word since the last end word) gets correct parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | Input word is the first (header) word |
| in_eop | input | 1 | Input word is the last word |
| in_data | input | 32 | Input word; bits [9:0] of a start word carry the length field |
| cfg_bad_en | input | 1 | Enables parity corruption for matching packets |
| cfg_match_len | input | 10 | Length value that selects a packet for corruption |
| out_valid | output | 1 | Output word present |
| out_sop | output | 1 | Output start flag |
| out_eop | output | 1 | Output end flag |
| out_data | output | 32 | Output word |
| out_par | output | 1 | Parity bit for `out_data` |

## Verification
The only state is an in-packet flag and a held corruption decision. A wrong decision shows as wrong parity on the first word of a packet, one cycle after the start word. A decision that is held wrongly or cleared wrongly shows on the next word of the same packet, or on the first stray word after the packet ends. The bench predicts parity for every word from the configuration it applied at each start word. It changes that configuration in the middle of packets and adds idle gaps. A decision that followed live configuration would then show as wrong parity within one word of the change.

// File: rtl/wpar_pkg.sv
package wpar_pkg;
  // Default widths shared by the parity path
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned LEN_W_DEF  = 10;

  // Framing flags carried alongside each word
  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
  } wpar_frame_t;
endpackage

// File: rtl/wpar_xor_tree.sv
// Balanced XOR reduction; output is 1 when the input has an odd count of ones.
module wpar_xor_tree #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] din,
  output logic         odd
);
  localparam int unsigned LVLS = (W > 1) ? $clog2(W) : 0;
  localparam int unsigned P    = 1 << LVLS;

  logic [P-1:0] padded;

  always_comb begin
    padded = '0;
    padded[W-1:0] = din;
  end

  for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lvl
    logic [(P >> lv)-1:0] v;
    if (lv == 0) begin : g_leaf
      assign v = padded;
    end else begin : g_node
      for (genvar j = 0; j < (P >> lv); j++) begin : g_pair
        assign v[j] = g_lvl[lv-1].v[2*j] ^ g_lvl[lv-1].v[2*j+1];
      end
    end
  end

  assign odd = g_lvl[LVLS].v[0];
endmodule

// File: rtl/wpar_inject_ctl.sv
// Decides, on each start word, whether the packet's parity is corrupted and
// holds that decision until the end word.
module wpar_inject_ctl #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic             cfg_bad_en,
  input  logic [LEN_W-1:0] cfg_match_len,
  output logic             inject_word
);
  logic in_pkt_q, in_pkt_d;
  logic hold_q, hold_d;
  logic start, len_hit, state_en;

  always_comb begin
    start    = in_valid & in_sop;
    len_hit  = cfg_bad_en & (hdr_len == cfg_match_len);
    state_en = in_valid;
    in_pkt_d = in_pkt_q;
    hold_d   = hold_q;
    if (start) begin
      in_pkt_d = ~in_eop;
      hold_d   = len_hit & ~in_eop;
    end else if (in_eop) begin
      in_pkt_d = 1'b0;
      hold_d   = 1'b0;
    end
    inject_word = start ? len_hit : (in_pkt_q & hold_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (state_en) begin
      in_pkt_q <= in_pkt_d;
      hold_q   <= hold_d;
    end
  end

  // R6 / R9: decision only changes on a start or end word
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && !(in_valid && (in_sop || in_eop))) |=> $stable(hold_q));

  // R10: no held decision outside a packet
  assert_no_hold_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_pkt_q |-> !hold_q);

  // R3: disabled mode never corrupts a start word
  assert_no_inject_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && !cfg_bad_en) |-> !inject_word);
endmodule

// File: rtl/wpar_out_stage.sv
// Output register: framing, data and final parity bit.
module wpar_out_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wpar_pkg::wpar_frame_t frm_in,
  input  logic [WORD_W-1:0]    data_in,
  input  logic                 odd_in,
  input  logic                 inject_in,
  output wpar_pkg::wpar_frame_t frm_out,
  output logic [WORD_W-1:0]    data_out,
  output logic                 par_out
);
  logic              vld_q;
  logic              sop_q, eop_q, par_q, bad_q;
  logic [WORD_W-1:0] data_q;
  logic              par_d, load_en;

  always_comb begin
    load_en = frm_in.valid;
    par_d   = odd_in ^ inject_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= frm_in.valid;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      sop_q  <= frm_in.sop;
      eop_q  <= frm_in.eop;
      data_q <= data_in;
      par_q  <= par_d;
      bad_q  <= inject_in;
    end
  end

  always_comb begin
    frm_out.valid = vld_q;
    frm_out.sop   = sop_q;
    frm_out.eop   = eop_q;
    data_out      = data_q;
    par_out       = par_q;
  end

  // R1 / R4: parity over the word plus its bit is odd exactly when corrupted
  assert_par_relation_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ((^{data_q, par_q}) == bad_q));
endmodule

// File: rtl/wpar_gen.sv
module wpar_gen #(
  parameter int unsigned WORD_W = wpar_pkg::WORD_W_DEF,
  parameter int unsigned LEN_W  = wpar_pkg::LEN_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [WORD_W-1:0] in_data,
  input  logic              cfg_bad_en,
  input  logic [LEN_W-1:0]  cfg_match_len,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [WORD_W-1:0] out_data,
  output logic              out_par
);
  wpar_pkg::wpar_frame_t frm_in, frm_out;
  logic word_odd, inject_word;

  assign frm_in = '{valid: in_valid, sop: in_sop, eop: in_eop};

  wpar_xor_tree #(.W(WORD_W)) u_tree (
    .din (in_data),
    .odd (word_odd)
  );

  wpar_inject_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sop        (in_sop),
    .in_eop        (in_eop),
    .hdr_len       (in_data[LEN_W-1:0]),
    .cfg_bad_en    (cfg_bad_en),
    .cfg_match_len (cfg_match_len),
    .inject_word   (inject_word)
  );

  wpar_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_in    (frm_in),
    .data_in   (in_data),
    .odd_in    (word_odd),
    .inject_in (inject_word),
    .frm_out   (frm_out),
    .data_out  (out_data),
    .par_out   (out_par)
  );

  assign out_valid = frm_out.valid;
  assign out_sop   = frm_out.sop;
  assign out_eop   = frm_out.eop;

  // R2: one-cycle pass-through of words and idle cycles
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_data == $past(in_data)));
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8: nothing valid while reset is asserted
  always_comb begin
    if (!rst_n) assert_reset_quiet_R8: assert (!out_valid);
  end
endmodule

// File: tb/tb_wpar_gen.sv
module tb_wpar_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [31:0] in_data;
  logic        cfg_bad_en;
  logic [9:0]  cfg_match_len;
  logic        out_valid, out_sop, out_eop, out_par;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  wpar_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .cfg_bad_en(cfg_bad_en),
    .cfg_match_len(cfg_match_len), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data), .out_par(out_par)
  );

  // Monitor: pop and compare each output word
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected word: actual %h expected none", out_data);
      end else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_sop, out_eop, out_par, out_data} !== e) begin
          fails++;
          $display("FAIL %s: actual sop=%b eop=%b par=%b data=%h expected sop=%b eop=%b par=%b data=%h",
                   t, out_sop, out_eop, out_par, out_data, e[34], e[33], e[32], e[31:0]);
        end
      end
    end
  end

  task automatic put_word(input logic sop, input logic eop, input logic [31:0] d,
                          input logic inj, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
    exp_q.push_back({sop, eop, (^d) ^ inj, d});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 32'h0;
    end
  endtask

  // Expected corruption is decided from the configuration at the start word
  task automatic send_pkt(input logic [9:0] len, input int nw, input logic [31:0] seed,
                          input bit gaps, input bit mid_change, input string tag);
    logic inj;
    logic [31:0] d;
    inj = cfg_bad_en && (len == cfg_match_len);
    for (int i = 0; i < nw; i++) begin
      d = (i == 0) ? {seed[21:0], len} : (seed * (i + 3)) ^ {i[7:0], 24'h5a3c1e};
      put_word(i == 0, i == nw - 1, d, inj, tag);
      if (mid_change && i == 1) begin
        cfg_match_len = len;
        cfg_bad_en = ~cfg_bad_en;
      end
      if (gaps && (i % 2 == 0)) idle(2);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 32'h0;
    cfg_bad_en = 1'b0; cfg_match_len = 10'd5;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8: actual out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 / R3: disabled, including a length that equals the match value
    send_pkt(10'd3, 3, 32'hdeadbeef, 0, 0, "R1");
    send_pkt(10'd5, 4, 32'h13572468, 0, 0, "R3");
    idle(2);

    // R4 / R5: enabled
    cfg_bad_en = 1'b1; cfg_match_len = 10'd7;
    send_pkt(10'd7, 4, 32'h0badf00d, 0, 0, "R4");
    send_pkt(10'd6, 3, 32'hcafe1234, 0, 0, "R5");
    send_pkt(10'h3ff, 2, 32'h11110000, 0, 0, "R5");
    idle(1);
    // R9: gaps inside a corrupted packet
    send_pkt(10'd7, 5, 32'h2468ace0, 1, 0, "R9");
    // R7: one-word packets, matching and not
    send_pkt(10'd7, 1, 32'h00c0ffee, 0, 0, "R7");
    send_pkt(10'd8, 1, 32'h00beef00, 0, 0, "R7");
    idle(2);

    // R10: stray word after a corrupted packet
    send_pkt(10'd7, 3, 32'h55aa55aa, 0, 0, "R4");
    idle(1);
    put_word(1'b0, 1'b0, 32'h87654321, 1'b0, "R10");
    idle(2);

    // R6: config changes mid-packet, both directions
    cfg_bad_en = 1'b1; cfg_match_len = 10'd9;
    send_pkt(10'd9, 5, 32'h9999aaaa, 0, 1, "R6");
    idle(1);
    cfg_bad_en = 1'b0; cfg_match_len = 10'd1;
    send_pkt(10'd12, 5, 32'h7777bbbb, 1, 1, "R6");
    // next packet sees the new configuration (enabled, match 12)
    send_pkt(10'd12, 2, 32'h3c3c3c3c, 0, 0, "R6");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: actual %0d words missing expected 0", exp_q.size());
    end
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule